// File: doc/BRIEF.md
# External Interrupt Request Latch

This block collects external interrupt requests for a small microcontroller core and turns them into one pending signal that the CPU samples between instructions. It watches a dedicated active-low request input and a group of port inputs, all already synchronized to the core clock. A falling edge on any of them sets one shared request latch. A configuration input can also make a low level on the dedicated input set the latch.

The latched request is gated by the CPU's global interrupt mask and by a local enable bit. When an instruction has just finished, the block reports whether an interrupt is to be taken and which kind it is. A software-interrupt instruction is always taken and ignores both the mask and the enable. The CPU clears the latch by pulsing an acknowledge during the vector fetch. A request that arrives during the service routine is therefore latched and held. It becomes visible as soon as the mask is cleared on return.

The latch is a two-state machine. `LAT_IDLE` means no request is held and `LAT_HELD` means a request is held. The transition IDLE→HELD fires on any set condition. HELD→IDLE fires on acknowledge when no set condition is present in that cycle. A set condition always keeps or enters HELD. Every other case keeps the current state.

Top module: `xirq_latch`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), req_held, ext_pending and take_int are 0. take_src is 0. The edge history reads high, so an input that is high at reset release causes no request.
- R2: A high-to-low change of irq_n between two consecutive clock samples moves the latch to HELD at the next clock edge. With level_sens=0, an irq_n held low after an acknowledge does not set the latch again.
- R3: With level_sens=1, irq_n low at a clock edge sets the latch. An acknowledge while irq_n is still low leaves req_held at 1.
- R4: A high-to-low change on any bit of port_n sets the latch at the next edge. Port inputs are edge-sensitive only, whatever level_sens is.
- R5: ext_pending is 1 exactly when req_held=1, cpu_mask=0 and irq_enable=1.
- R6: take_int is 1 only in a cycle with insn_done=1. In that cycle take_src encodes the cause: 0 = none, 1 = external, 2 = software. Software takes priority over external.
- R7: With insn_done=1, swi_exec=1 yields take_int=1 and take_src=2 regardless of cpu_mask and irq_enable.
- R8: vec_ack=1 with no set condition in that cycle returns the latch to IDLE at the next edge.
- R9: When a set condition and vec_ack occur in the same cycle, the latch is HELD after the edge.
- R10: A request latched while cpu_mask=1 or irq_enable=0 stays held. ext_pending rises in the same cycle that the mask clears or the enable sets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_n | input | 1 | Dedicated request input, active low, synchronized |
| port_n | input | NPORT | Port request inputs, falling-edge sensitive |
| level_sens | input | 1 | 1 = dedicated input is edge and low-level sensitive |
| cpu_mask | input | 1 | Global interrupt mask, 1 = masked |
| irq_enable | input | 1 | Local external interrupt enable |
| insn_done | input | 1 | Current instruction completes this cycle |
| vec_ack | input | 1 | Vector-fetch acknowledge, clears the latch |
| swi_exec | input | 1 | Software-interrupt instruction at this boundary |
| req_held | output | 1 | Latch state (1 = LAT_HELD) |
| ext_pending | output | 1 | Gated external request |
| take_int | output | 1 | Interrupt to be taken at this boundary |
| take_src | output | 2 | Cause: 0 none, 1 external, 2 software |

## Verification
The hardest case to reach is a collision: a fresh falling edge in the exact cycle of the acknowledge. A close second is a low level still present on the acknowledge cycle. The stimulus first sets the latch, then raises the input for one cycle. It then drops the input in the same cycle that it pulses vec_ack. Other sequences hold the input low across the acknowledge in both sensitivity modes, so the two modes are compared on identical input. A behavioural reference model follows every clock edge. Its latch and gating results are compared with the outputs on every cycle, including cycles of random stimulus.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
    typedef enum logic {
        LAT_IDLE = 1'b0,
        LAT_HELD = 1'b1
    } lat_state_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_SWI  = 2'd2
    } src_t;
endpackage

// File: rtl/xirq_edge_detect.sv
module xirq_edge_detect #(
    parameter int NPORT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_n,
    input  logic [NPORT-1:0] port_n,
    input  logic             level_sens,
    output logic             set_req
);
    logic             irq_q;
    logic [NPORT-1:0] port_q;
    logic [NPORT-1:0] port_fall;
    logic             irq_fall;
    logic             irq_level;

    // history starts high so a high input at release is not an edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q  <= 1'b1;
            port_q <= '1;
        end else begin
            irq_q  <= irq_n;
            port_q <= port_n;
        end
    end

    generate
        for (genvar i = 0; i < NPORT; i++) begin : g_port
            assign port_fall[i] = port_q[i] & ~port_n[i];
        end
    endgenerate

    assign irq_fall  = irq_q & ~irq_n;
    assign irq_level = level_sens & ~irq_n;

    always_comb begin
        set_req = irq_fall | irq_level | (|port_fall);
    end
endmodule

// File: rtl/xirq_req_fsm.sv
module xirq_req_fsm
    import xirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic vec_ack,
    output logic req_held
);
    lat_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LAT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LAT_IDLE: if (set_req) state_d = LAT_HELD;
            LAT_HELD: if (!set_req && vec_ack) state_d = LAT_IDLE;
            default:  state_d = LAT_IDLE;
        endcase
    end

    always_comb begin
        req_held = (state_q == LAT_HELD);
    end
endmodule

// File: rtl/xirq_gate.sv
module xirq_gate
    import xirq_pkg::*;
(
    input  logic       req_held,
    input  logic       cpu_mask,
    input  logic       irq_enable,
    input  logic       insn_done,
    input  logic       swi_exec,
    output logic       ext_pending,
    output logic       take_int,
    output logic [1:0] take_src
);
    src_t src;

    always_comb begin
        ext_pending = req_held & ~cpu_mask & irq_enable;
        src = SRC_NONE;
        if (insn_done) begin
            if (swi_exec)         src = SRC_SWI;
            else if (ext_pending) src = SRC_EXT;
        end
        take_int = (src != SRC_NONE);
        take_src = src;
    end
endmodule

// File: rtl/xirq_latch.sv
module xirq_latch #(
    parameter int NPORT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_n,
    input  logic [NPORT-1:0] port_n,
    input  logic             level_sens,
    input  logic             cpu_mask,
    input  logic             irq_enable,
    input  logic             insn_done,
    input  logic             vec_ack,
    input  logic             swi_exec,
    output logic             req_held,
    output logic             ext_pending,
    output logic             take_int,
    output logic [1:0]       take_src
);
    logic set_req;

    xirq_edge_detect #(.NPORT(NPORT)) u_edge (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .port_n(port_n),
        .level_sens(level_sens), .set_req(set_req)
    );

    xirq_req_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .set_req(set_req),
        .vec_ack(vec_ack), .req_held(req_held)
    );

    xirq_gate u_gate (
        .req_held(req_held), .cpu_mask(cpu_mask), .irq_enable(irq_enable),
        .insn_done(insn_done), .swi_exec(swi_exec),
        .ext_pending(ext_pending), .take_int(take_int), .take_src(take_src)
    );
endmodule

// File: rtl/xirq_latch_checker.sv
module xirq_latch_checker #(
    parameter int NPORT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_n,
    input logic [NPORT-1:0] port_n,
    input logic             cpu_mask,
    input logic             irq_enable,
    input logic             insn_done,
    input logic             vec_ack,
    input logic             swi_exec,
    input logic             req_held,
    input logic             ext_pending,
    input logic             take_int,
    input logic [1:0]       take_src
);
    p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(irq_n) && !irq_n) |=> req_held);

    p_pend_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ext_pending |-> (!cpu_mask && irq_enable));

    p_take_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |-> insn_done);

    p_swi_unmasked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && swi_exec) |-> (take_int && take_src == 2'd2));

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack && irq_n && (&port_n)) |=> !req_held);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_held && !vec_ack) |=> req_held);
endmodule

bind xirq_latch xirq_latch_checker #(.NPORT(NPORT)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .port_n(port_n),
    .cpu_mask(cpu_mask), .irq_enable(irq_enable), .insn_done(insn_done),
    .vec_ack(vec_ack), .swi_exec(swi_exec), .req_held(req_held),
    .ext_pending(ext_pending), .take_int(take_int), .take_src(take_src)
);

// File: tb/xirq_latch_tb.sv
module xirq_latch_tb;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          irq_n = 1'b1;
    logic [NP-1:0] port_n = '1;
    logic          level_sens = 1'b0;
    logic          cpu_mask = 1'b0;
    logic          irq_enable = 1'b1;
    logic          insn_done = 1'b0;
    logic          vec_ack = 1'b0;
    logic          swi_exec = 1'b0;
    logic          req_held, ext_pending, take_int;
    logic [1:0]    take_src;

    int    n_chk = 0;
    int    n_bad = 0;
    string tag = "R1";

    // reference model state
    bit          m_lat = 0;
    bit          m_pi = 1;
    bit [NP-1:0] m_pp = '1;

    always #2 clk = ~clk;

    xirq_latch #(.NPORT(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .port_n(port_n),
        .level_sens(level_sens), .cpu_mask(cpu_mask), .irq_enable(irq_enable),
        .insn_done(insn_done), .vec_ack(vec_ack), .swi_exec(swi_exec),
        .req_held(req_held), .ext_pending(ext_pending),
        .take_int(take_int), .take_src(take_src)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lat = 0; m_pi = 1; m_pp = '1;
        end else begin
            bit s;
            s = (m_pi && !irq_n) || (level_sens && !irq_n) || ((m_pp & ~port_n) != 0);
            if (s)            m_lat = 1;
            else if (vec_ack) m_lat = 0;
            m_pi = irq_n;
            m_pp = port_n;
        end
    end

    task automatic cmp(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        bit pend;
        int src;
        pend = m_lat && !cpu_mask && irq_enable;
        src  = !insn_done ? 0 : swi_exec ? 2 : pend ? 1 : 0;
        cmp("req_held", req_held, m_lat);
        cmp("ext_pending", ext_pending, pend);
        cmp("take_int", take_int, src != 0);
        cmp("take_src", take_src, src);
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(3);
        tag = "R1"; rst_n = 1; step(3);
        // R2 edge mode: held low does not re-trigger after ack
        tag = "R2"; irq_n = 0; step(3);
        tag = "R8"; vec_ack = 1; step(1); vec_ack = 0;
        tag = "R2"; step(4); irq_n = 1; step(2);
        // R3 level mode keeps latch set across ack
        tag = "R3"; level_sens = 1; irq_n = 0; step(2);
        vec_ack = 1; step(1); vec_ack = 0; step(1);
        irq_n = 1; step(1);
        tag = "R8"; vec_ack = 1; step(1); vec_ack = 0; step(2);
        level_sens = 0;
        // R4 each port, also under level mode
        tag = "R4";
        for (int i = 0; i < NP; i++) begin
            level_sens = i[0];
            port_n[i] = 0; step(3);
            vec_ack = 1; step(1); vec_ack = 0; step(2);
            port_n[i] = 1; step(1);
        end
        level_sens = 0;
        // R10 held under mask and disable
        tag = "R10"; cpu_mask = 1; irq_n = 0; step(1); irq_n = 1; step(3);
        insn_done = 1; step(1); cpu_mask = 0; step(1); insn_done = 0;
        irq_enable = 0; step(2); irq_enable = 1; step(1);
        tag = "R6"; insn_done = 1; step(1); insn_done = 0; step(1);
        tag = "R8"; vec_ack = 1; step(1); vec_ack = 0; step(1);
        // R7 software interrupt ignores gating
        tag = "R7"; cpu_mask = 1; irq_enable = 0; swi_exec = 1; step(1);
        insn_done = 1; step(2); cpu_mask = 0; irq_enable = 1; irq_n = 0; step(2);
        tag = "R6"; swi_exec = 0; step(1); insn_done = 0; irq_n = 1; step(1);
        // R9 set and ack collide
        tag = "R9"; irq_n = 1; step(1); irq_n = 0; vec_ack = 1; step(1);
        vec_ack = 0; step(2);
        irq_n = 1; vec_ack = 1; step(1); vec_ack = 0; step(1);
        port_n[2] = 0; vec_ack = 1; step(1); vec_ack = 0; port_n[2] = 1; step(2);
        // R5 random gating and traffic
        tag = "R5";
        for (int k = 0; k < 400; k++) begin
            irq_n      = ($urandom % 4) != 0;
            port_n     = NP'($urandom) | NP'($urandom);
            level_sens = ($urandom % 8) == 0;
            cpu_mask   = $urandom % 2;
            irq_enable = ($urandom % 4) != 0;
            insn_done  = $urandom % 2;
            vec_ack    = ($urandom % 3) == 0;
            swi_exec   = ($urandom % 6) == 0;
            step(1);
        end
        tag = "R1"; rst_n = 0; irq_n = 1; port_n = '1; step(2); rst_n = 1; step(3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule